// File: doc/BRIEF.md
# Range-Gated Two's-Complement Adder/Subtractor

This block adds or subtracts two 16-bit two's-complement operands and cuts switching activity in its upper half whenever the operands are small. The datapath is split into a lower slice (bits 7:0) and an upper slice (bits 15:8). A range detector looks at each incoming operation. The upper slice is needed when either operand does not fit in 8-bit signed form, or when the 8-bit lower sum overflows. The operand for subtraction is the inverted B with a carry-in of one.

When the upper slice is needed, its operand registers load fresh bits. When it is not needed, those registers keep their old contents, so the upper adder's inputs do not toggle. A sign-extension path then fills result bits 15:8 with the sign of the lower sum. The result appears one clock after a valid input. A status output shows whether the upper slice took part in that result.

Top module: `guarded_addsub`

## Requirements
- R1: One cycle after a cycle with `valid_i` high, `valid_o` is high and `sum_o` equals A+B (when `sub_i`=0) or A−B (when `sub_i`=1), modulo 2^16.
- R2: The effective B is B when `sub_i`=0 and ~B when `sub_i`=1. One cycle after a valid input, `hi_active_o` is low if both of the following hold, and high otherwise: bits 15:7 of A are all equal and bits 15:7 of the effective B are all equal, and the lower 8-bit signed sum does not overflow.
- R3: Whenever `valid_o` is high and `hi_active_o` is low, every bit of `sum_o[15:8]` equals `sum_o[7]`.
- R4: A signed overflow of the 8-bit lower sum forces `hi_active_o` high, even when both operands fit in 8 bits. The lower sum is A[7:0] + effective B[7:0] + `sub_i`, and overflow means the carry into bit 7 differs from the carry out of bit 7.
- R5: The upper operand registers change only on a cycle with `valid_i` high and the upper slice needed; otherwise they hold. Values left in them from earlier operations never corrupt a later result.
- R6: A synchronous active-high `rst_i` drives `valid_o`, `hi_active_o` and `sum_o` to zero on the next cycle and clears the upper operand registers.
- R7: One cycle after a cycle with `valid_i` low, both `valid_o` and `hi_active_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation request this cycle |
| sub_i | input | 1 | 0 = add, 1 = subtract (A − B) |
| a_i | input | 16 | Operand A, two's complement |
| b_i | input | 16 | Operand B, two's complement |
| valid_o | output | 1 | Result valid |
| sum_o | output | 16 | Result, one cycle after the request |
| hi_active_o | output | 1 | Upper slice computed this result |

## Verification
The bench builds the block with its default parameters: a 16-bit width and an 8-bit lower slice. These values make the gating boundaries reachable with short directed operands. They include the signed limits 127 and −128 on either side of the split, subtraction of −128 (whose inverted form fits but whose sum overflows), and the wrap from 0x7FFF to 0x8000. A wide–narrow–wide sequence shows that values held in the frozen upper registers never leak into the next wide result. A long random mix of narrow, wide and idle cycles then exercises the detector on back-to-back operations.

// File: rtl/gas_pkg.sv
package gas_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    localparam int DEF_WIDTH = 16;
    localparam int DEF_LO_W  = 8;

endpackage

// File: rtl/gas_lo_add.sv
module gas_lo_add #(
    parameter int LO_W = 8
) (
    input  logic [LO_W-1:0] a_i,
    input  logic [LO_W-1:0] b_i,
    input  logic            c_i,
    output logic [LO_W-1:0] sum_o,
    output logic            c_o,
    output logic            ovf_o
);
    localparam int BODY_W = LO_W - 1;

    logic [LO_W-1:0] body;
    logic [1:0]      msb;
    logic            c_into_msb;

    always_comb begin
        body       = {1'b0, a_i[BODY_W-1:0]} + {1'b0, b_i[BODY_W-1:0]}
                   + {{BODY_W{1'b0}}, c_i};
        c_into_msb = body[BODY_W];
        msb        = {1'b0, a_i[LO_W-1]} + {1'b0, b_i[LO_W-1]} + {1'b0, c_into_msb};
        sum_o      = {msb[0], body[BODY_W-1:0]};
        c_o        = msb[1];
        ovf_o      = c_into_msb ^ msb[1];
    end

endmodule

// File: rtl/gas_detect.sv
module gas_detect #(
    parameter int WIDTH = 16,
    parameter int LO_W  = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             ovf_i,
    output logic             need_o
);
    localparam int CHK_W = WIDTH - LO_W + 1;

    logic [1:0] narrow;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        logic [CHK_W-1:0] top_bits;
        assign top_bits  = (g == 0) ? a_i[WIDTH-1:LO_W-1] : b_i[WIDTH-1:LO_W-1];
        assign narrow[g] = (&top_bits) | ~(|top_bits);
    end

    assign need_o = ~(&narrow) | ovf_i;

endmodule

// File: rtl/gas_hi_add.sv
module gas_hi_add #(
    parameter int HI_W = 8
) (
    input  logic [HI_W-1:0] a_i,
    input  logic [HI_W-1:0] b_i,
    input  logic            c_i,
    output logic [HI_W-1:0] sum_o
);
    always_comb begin
        sum_o = a_i + b_i + {{(HI_W-1){1'b0}}, c_i};
    end

endmodule

// File: rtl/guarded_addsub.sv
module guarded_addsub
    import gas_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    parameter int LO_W  = DEF_LO_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             valid_i,
    input  logic             sub_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             valid_o,
    output logic [WIDTH-1:0] sum_o,
    output logic             hi_active_o
);
    localparam int HI_W = WIDTH - LO_W;

    typedef struct packed {
        logic            vld;
        logic            act;
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] ha;
        logic [HI_W-1:0] hb;
        logic            hc;
    } st_t;

    st_t st_d, st_q;

    logic [WIDTH-1:0] b_eff;
    logic [LO_W-1:0]  lo_sum;
    logic             lo_co;
    logic             lo_ovf;
    logic             hi_need;
    logic             hi_load;
    logic [HI_W-1:0]  hi_sum;
    logic [HI_W-1:0]  hi_fill;
    logic [2*HI_W:0]  hi_ops_q;

    assign b_eff = (op_e'(sub_i) == OP_SUB) ? ~b_i : b_i;

    gas_lo_add #(.LO_W(LO_W)) u_lo (
        .a_i   (a_i[LO_W-1:0]),
        .b_i   (b_eff[LO_W-1:0]),
        .c_i   (sub_i),
        .sum_o (lo_sum),
        .c_o   (lo_co),
        .ovf_o (lo_ovf)
    );

    gas_detect #(.WIDTH(WIDTH), .LO_W(LO_W)) u_det (
        .a_i    (a_i),
        .b_i    (b_eff),
        .ovf_i  (lo_ovf),
        .need_o (hi_need)
    );

    assign hi_load = valid_i & hi_need;

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        st_d.act = hi_load;
        if (valid_i) begin
            st_d.lo = lo_sum;
        end
        if (hi_load) begin
            st_d.ha = a_i[WIDTH-1:LO_W];
            st_d.hb = b_eff[WIDTH-1:LO_W];
            st_d.hc = lo_co;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    gas_hi_add #(.HI_W(HI_W)) u_hi (
        .a_i   (st_q.ha),
        .b_i   (st_q.hb),
        .c_i   (st_q.hc),
        .sum_o (hi_sum)
    );

    always_comb begin
        hi_fill = st_q.act ? hi_sum : {HI_W{st_q.lo[LO_W-1]}};
    end

    assign hi_ops_q    = {st_q.ha, st_q.hb, st_q.hc};
    assign valid_o     = st_q.vld;
    assign hi_active_o = st_q.act;
    assign sum_o       = {hi_fill, st_q.lo};

endmodule

// File: rtl/gas_chk.sv
module gas_chk #(
    parameter int WIDTH = 16,
    parameter int LO_W  = 8
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               valid_i,
    input logic               sub_i,
    input logic [WIDTH-1:0]   a_i,
    input logic [WIDTH-1:0]   b_i,
    input logic               valid_o,
    input logic [WIDTH-1:0]   sum_o,
    input logic               hi_active_o,
    input logic               hi_load_i,
    input logic [2*(WIDTH-LO_W):0] hi_ops_i
);
    localparam int HI_W = WIDTH - LO_W;

    logic [WIDTH-1:0] ref_sum;
    logic [WIDTH-1:0] beff;
    logic             a_fits;
    logic             b_fits;
    logic [LO_W:0]    lo_ext;
    logic             lo_ovf;

    always_comb begin
        ref_sum = sub_i ? (a_i - b_i) : (a_i + b_i);
        beff    = sub_i ? ~b_i : b_i;
        a_fits  = (a_i  == {{HI_W{a_i[LO_W-1]}},  a_i[LO_W-1:0]});
        b_fits  = (beff == {{HI_W{beff[LO_W-1]}}, beff[LO_W-1:0]});
        lo_ext  = {a_i[LO_W-1], a_i[LO_W-1:0]} + {beff[LO_W-1], beff[LO_W-1:0]}
                + {{LO_W{1'b0}}, sub_i};
        lo_ovf  = lo_ext[LO_W] ^ lo_ext[LO_W-1];
    end

    AST_SUM_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |=> (valid_o && sum_o == $past(ref_sum))); // R1

    AST_WIDE_ACTIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && !(a_fits && b_fits)) |=> hi_active_o); // R2

    AST_NARROW_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && a_fits && b_fits && !lo_ovf) |=> !hi_active_o); // R2

    AST_SIGN_FILL: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && !hi_active_o) |-> (sum_o[WIDTH-1:LO_W] == {HI_W{sum_o[LO_W-1]}})); // R3

    AST_LO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && lo_ovf) |=> hi_active_o); // R4

    AST_HI_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        !hi_load_i |=> $stable(hi_ops_i)); // R5

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (!valid_o && !hi_active_o && sum_o == '0 && hi_ops_i == '0)); // R6

    AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> (!valid_o && !hi_active_o)); // R7

endmodule

bind guarded_addsub gas_chk #(.WIDTH(WIDTH), .LO_W(LO_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .valid_i     (valid_i),
    .sub_i       (sub_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .valid_o     (valid_o),
    .sum_o       (sum_o),
    .hi_active_o (hi_active_o),
    .hi_load_i   (hi_load),
    .hi_ops_i    (hi_ops_q)
);

// File: tb/guarded_addsub_tb.sv
module guarded_addsub_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 16;
    localparam int LO_W       = 8;

    logic             clk_i = 1'b0;
    logic             rst_i = 1'b1;
    logic             valid_i = 1'b0;
    logic             sub_i = 1'b0;
    logic [WIDTH-1:0] a_i = '0;
    logic [WIDTH-1:0] b_i = '0;
    logic             valid_o;
    logic [WIDTH-1:0] sum_o;
    logic             hi_active_o;

    typedef struct {
        logic             vld;
        logic [WIDTH-1:0] sum;
        logic             act;
        string            sum_tag;
        string            act_tag;
    } item_t;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    guarded_addsub #(.WIDTH(WIDTH), .LO_W(LO_W)) u_dut (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .valid_i     (valid_i),
        .sub_i       (sub_i),
        .a_i         (a_i),
        .b_i         (b_i),
        .valid_o     (valid_o),
        .sum_o       (sum_o),
        .hi_active_o (hi_active_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic item_t model(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                                    input logic sub, input string tag);
        item_t it;
        logic [WIDTH-1:0] be;
        int sa, sb, la, lb, ls;
        bit narrow, ovf;
        be     = sub ? ~b : b;
        sa     = int'($signed(a));
        sb     = int'($signed(be));
        la     = int'($signed(a[LO_W-1:0]));
        lb     = int'($signed(be[LO_W-1:0]));
        ls     = la + lb + (sub ? 1 : 0);
        narrow = (sa >= -128) && (sa <= 127) && (sb >= -128) && (sb <= 127);
        ovf    = (ls > 127) || (ls < -128);
        it.vld     = 1'b1;
        it.sum     = sub ? (a - b) : (a + b);
        it.act     = !narrow || ovf;
        it.sum_tag = tag;
        it.act_tag = (narrow && ovf) ? "R4" : "R2";
        return it;
    endfunction

    task automatic op(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                      input logic sub, input string tag);
        @(negedge clk_i);
        valid_i = 1'b1;
        sub_i   = sub;
        a_i     = a;
        b_i     = b;
        q.push_back(model(a, b, sub, tag));
    endtask

    task automatic idle();
        item_t it;
        @(negedge clk_i);
        valid_i    = 1'b0;
        a_i        = 16'hA5A5;
        b_i        = 16'h5A5A;
        it.vld     = 1'b0;
        it.sum     = '0;
        it.act     = 1'b0;
        it.sum_tag = "R7";
        it.act_tag = "R7";
        q.push_back(it);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: pops one expected item per clock, a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk_i);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                if (it.vld) begin
                    check(valid_o === 1'b1, "R1", "valid_o", {15'b0, valid_o}, 16'h1);
                    check(sum_o === it.sum, it.sum_tag, "sum_o", sum_o, it.sum);
                    check(hi_active_o === it.act, it.act_tag, "hi_active_o",
                          {15'b0, hi_active_o}, {15'b0, it.act});
                    if (!it.act)
                        check(sum_o[WIDTH-1:LO_W] === {(WIDTH-LO_W){sum_o[LO_W-1]}}, "R3",
                              "sign fill", sum_o, {{(WIDTH-LO_W){sum_o[LO_W-1]}}, sum_o[LO_W-1:0]});
                end else begin
                    check(valid_o === 1'b0 && hi_active_o === 1'b0, "R7", "idle outputs",
                          {14'b0, valid_o, hi_active_o}, 16'h0);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        // r6_ reset state
        check(valid_o === 1'b0, "R6", "valid_o after reset", {15'b0, valid_o}, 16'h0);
        check(sum_o === '0, "R6", "sum_o after reset", sum_o, 16'h0);
        check(hi_active_o === 1'b0, "R6", "hi_active_o after reset", {15'b0, hi_active_o}, 16'h0);
        rst_i = 1'b0;

        op(16'd5,    16'd3,    1'b0, "R1");   // narrow add
        op(16'hFFFD, 16'hFFFB, 1'b0, "R1");   // -3 + -5
        op(16'd100,  16'd100,  1'b0, "R4");   // lower overflow
        op(16'hFF9C, 16'hFF9C, 1'b0, "R4");   // -100 + -100
        op(16'h1234, 16'h0001, 1'b0, "R1");   // wide
        op(16'd10,   16'd20,   1'b1, "R1");   // 10 - 20 narrow
        op(16'd0,    16'h0080, 1'b1, "R2");   // B=128 wide after inversion
        op(16'd5,    16'hFF80, 1'b1, "R4");   // 5 - (-128) overflow
        op(16'd0,    16'hFF80, 1'b1, "R4");   // 0 - (-128)
        op(16'h007F, 16'd0,    1'b0, "R2");   // +127 boundary
        op(16'hFF80, 16'd0,    1'b0, "R2");   // -128 boundary
        op(16'h0080, 16'd0,    1'b0, "R2");   // 128 just outside
        op(16'h7FFF, 16'd1,    1'b0, "R1");   // wrap to 0x8000
        op(16'h8000, 16'd1,    1'b1, "R1");   // wrap to 0x7FFF
        idle();
        // R5: wide, narrow, then wide with different upper bits
        op(16'h4321, 16'h1111, 1'b0, "R5");
        op(16'd7,    16'd9,    1'b1, "R5");
        op(16'h00F0, 16'h2200, 1'b1, "R5");
        idle();
        idle();

        for (int i = 0; i < 400; i++) begin
            logic [WIDTH-1:0] ra, rb;
            int mode;
            mode = int'($urandom_range(0, 4));
            ra   = WIDTH'($urandom);
            rb   = WIDTH'($urandom);
            if (mode < 2) begin
                ra = {{(WIDTH-LO_W){ra[LO_W-1]}}, ra[LO_W-1:0]};
                rb = {{(WIDTH-LO_W){rb[LO_W-1]}}, rb[LO_W-1:0]};
            end
            if (mode == 4) idle();
            else op(ra, rb, 1'($urandom), "R1");
        end
        idle();

        while (q.size() > 0) @(posedge clk_i);
        @(negedge clk_i);
        done = 1;
        report();
    end

endmodule